// File: doc/BRIEF.md
# Asynchronous Serial Byte Receiver

This block turns one asynchronous serial line into parallel bytes. A frame holds, in order, a low start bit, eight data bits with the least significant bit first, an optional parity bit and a stop bit. The line passes through a two-flop synchronizer. A programmable divisor produces a 16x oversampling tick, and every bit is sampled at its middle, counted from the falling edge that opened the frame. The receiver only runs while both a power-enable pin and a receive-enable pin are high.

A start is found in two steps. The synchronized line must first be seen high. The next falling edge then begins the start-bit timing, and the start bit is kept only if the line is still low at its middle. Every frame that gets past the start bit runs to its stop-bit position, even when it has a parity or framing error. At that point the block pulses a completion interrupt and offers the byte on a valid/ready output.

Back-pressure rules for the output: `rd_valid` stays high until a cycle with `rd_valid && rd_ready`, and that cycle is a read. If a frame completes while a byte is still pending and no read happens in that same cycle, the new byte is dropped, the held byte stays, and the overrun flag is set. A read in the completion cycle frees the holding register, so the new byte is loaded with no overrun.

Top module: `serial_rx_unit`

## Requirements
- R1: The receiver ignores the line and never completes a frame unless `pwr_en` and `rx_en` are both 1.
- R2: A falling edge counts as a start only after the synchronized line has been seen high while enabled. A line held low from the moment of enabling produces no frame.
- R3: If the line is high at the middle of the start bit, the start is rejected and the receiver waits for the line to go high again. No completion occurs.
- R4: Data bits are taken LSB first into `rd_data`. `done_irq` is a one-cycle pulse. With a divisor of 1 it is seen 156 clocks after the start bit is driven without parity, and 172 clocks after with parity.
- R5: `par_mode` selects 0 = none, 1 = even, 2 = odd, 3 = none. With parity on, a parity bit that does not match sets `err_parity` for that frame. With parity off, there is no parity slot.
- R6: A stop bit sampled low sets `err_frame`. The byte is still delivered and `done_irq` still pulses.
- R7: A completion while `rd_valid` is 1 and `rd_ready` is 0 keeps the old `rd_data`, keeps `rd_valid` at 1 and sets `err_overrun`.
- R8: A cycle with `rd_valid && rd_ready` clears `rd_valid`. A completion in such a cycle loads the new byte with `err_overrun` at 0.
- R9: One bit lasts 16 × `baud_div` clocks. A `baud_div` of 0 behaves as 1.
- R10: Error flags change only when a frame completes. After reset, `rd_valid`, `rd_data`, `done_irq` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Power enable (first stage of arming) |
| rx_en | input | 1 | Receive enable (second stage of arming) |
| baud_div | input | 16 | Clocks per oversampling tick (0 treated as 1) |
| par_mode | input | 2 | Parity select: 0 none, 1 even, 2 odd, 3 none |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Byte pending |
| rd_ready | input | 1 | Consumer accepts byte |
| err_parity | output | 1 | Parity mismatch in last completed frame |
| err_frame | output | 1 | Stop bit low in last completed frame |
| err_overrun | output | 1 | Last completed byte dropped because of a pending byte |
| done_irq | output | 1 | One-cycle frame completion pulse |

## Verification
The start bit reaches the frame logic after two synchronizer clocks. The stop-bit middle falls 152 ticks later, or 168 ticks later with parity, and the output stage adds one more register. So at a divisor of 1, `done_irq`, `rd_data`, `rd_valid` and the three flags all change together, 156 or 172 clocks after the start bit is driven. The bench drives the line at falling clock edges, counts falling edges from the start bit and records the count at which `done_irq` is first seen high; that count must match exactly. The output values are sampled only after the frame has ended. To hit the same-cycle read of R8, `rd_ready` is raised at the falling edge just before the completion edge, which is count 155.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE2 = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_HIGH,
    ST_WAIT_FALL,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                cnt <= '0;
    else if (restart || tick)  cnt <= '0;
    else                       cnt <= cnt + 1'b1;

  // R9: with a divisor above 1, ticks are never on consecutive cycles
  a_r9_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0 && !restart) |=> (!tick || div != $past(div)));
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              rx_s,
  input  logic              tick,
  input  logic [1:0]        par_mode,
  output logic              restart,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int OS_W  = $clog2(OS);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OS_W-1:0]  MID   = OS_W'(OS / 2 - 1);
  localparam logic [OS_W-1:0]  LAST  = OS_W'(OS - 1);
  localparam logic [BIT_W-1:0] TOP   = BIT_W'(DATA_W - 1);

  rx_state_e         state;
  logic [OS_W-1:0]   os_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] shreg;
  logic              par_bit;
  logic              par_on;
  logic              exp_par;
  logic              at_mid;

  assign par_on  = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);
  assign exp_par = (par_mode == PAR_ODD) ? ~(^shreg) : (^shreg);
  assign restart = active && (state == ST_WAIT_FALL) && !rx_s;
  assign at_mid  = tick && (os_cnt == LAST);
  assign data    = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      os_cnt  <= '0;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        state <= ST_OFF;
      end else begin
        case (state)
          ST_OFF:       state <= ST_WAIT_HIGH;
          ST_WAIT_HIGH: if (rx_s) state <= ST_WAIT_FALL;
          ST_WAIT_FALL: if (!rx_s) begin
            state  <= ST_START;
            os_cnt <= '0;
          end
          ST_START: if (tick) begin
            if (os_cnt == MID) begin
              os_cnt <= '0;
              if (!rx_s) begin
                state   <= ST_DATA;
                bit_idx <= '0;
              end else begin
                state <= ST_WAIT_HIGH;
              end
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_DATA: if (tick) begin
            if (at_mid) begin
              os_cnt <= '0;
              shreg  <= {rx_s, shreg[DATA_W-1:1]};
              if (bit_idx == TOP) state <= par_on ? ST_PAR : ST_STOP;
              else                bit_idx <= bit_idx + 1'b1;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_PAR: if (tick) begin
            if (at_mid) begin
              os_cnt  <= '0;
              par_bit <= rx_s;
              state   <= ST_STOP;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_STOP: if (tick) begin
            if (at_mid) begin
              os_cnt <= '0;
              done   <= 1'b1;
              ferr   <= !rx_s;
              perr   <= par_on && (par_bit != exp_par);
              state  <= ST_WAIT_HIGH;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end

  // R1: disabling drops the receiver to its off state on the next edge
  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (state == ST_OFF));
  // R2: no start timing begins straight from the wait-for-high state
  a_r2_high_before_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_HIGH) |=> (state != ST_START));
  // R3: a high start-bit middle returns to waiting for high
  a_r3_reject_false_start: assert property (@(posedge clk) disable iff (!rst_n)
    (active && state == ST_START && tick && os_cnt == MID && rx_s) |=> (state == ST_WAIT_HIGH));
  // R4: completion from the frame logic lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              perr_in,
  input  logic              ferr_in,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              irq
);
  logic blocked;
  assign blocked = rd_valid && !rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      irq         <= 1'b0;
    end else begin
      irq <= done_in;
      if (done_in) begin
        err_parity <= perr_in;
        err_frame  <= ferr_in;
        if (blocked) begin
          err_overrun <= 1'b1;
        end else begin
          rd_data     <= data_in;
          rd_valid    <= 1'b1;
          err_overrun <= 1'b0;
        end
      end else if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end

  // R7: a blocked completion leaves the pending byte untouched
  a_r7_keep_on_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (done_in && rd_valid && !rd_ready) |=> ($stable(rd_data) && rd_valid && err_overrun));
  // R8: a read with no completion frees the register
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !done_in) |=> !rd_valid);
  // R10: flags move only on completion
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_in |=> ($stable(err_parity) && $stable(err_frame) && $stable(err_overrun)));
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              rx_en,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [1:0]        par_mode,
  input  logic              rx_line,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              done_irq
);
  logic              rx_s;
  logic              tick;
  logic              restart;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_perr;
  logic              f_ferr;
  logic              active;

  assign active = pwr_en && rx_en;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(rx_s)
  );

  rx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .restart(restart), .tick(tick)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OS(OS_RATE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .active(active), .rx_s(rx_s), .tick(tick),
    .par_mode(par_mode), .restart(restart), .done(f_done), .data(f_data),
    .perr(f_perr), .ferr(f_ferr)
  );

  rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .done_in(f_done), .data_in(f_data),
    .perr_in(f_perr), .ferr_in(f_ferr), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .irq(done_irq)
  );

  // R1: no completion pulse while the receiver is not armed
  a_r1_no_irq_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !f_done) |=> !done_irq);
endmodule

// File: tb/sim_serial_rx_unit.sv
module sim_serial_rx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_en = 1'b0;
  logic        rx_en = 1'b0;
  logic [15:0] baud_div = 16'd1;
  logic [1:0]  par_mode = 2'd0;
  logic        rx_line = 1'b1;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        err_parity;
  logic        err_frame;
  logic        err_overrun;
  logic        done_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  serial_rx_unit u0 (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .rx_en(rx_en), .baud_div(baud_div),
    .par_mode(par_mode), .rx_line(rx_line), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .done_irq(done_irq)
  );

  // vector: data[13:6], par_mode[5:4], flip parity[3], stop level[2], divisor[1:0]
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {8'hA5, 2'd0, 1'b0, 1'b1, 2'd1},
    {8'h3C, 2'd1, 1'b0, 1'b1, 2'd1},
    {8'h3D, 2'd2, 1'b0, 1'b1, 2'd1},
    {8'h81, 2'd1, 1'b1, 1'b1, 2'd1},
    {8'h7E, 2'd2, 1'b1, 1'b1, 2'd1},
    {8'hFF, 2'd0, 1'b0, 1'b0, 2'd1},
    {8'h00, 2'd3, 1'b0, 1'b1, 2'd1},
    {8'h5A, 2'd0, 1'b0, 1'b1, 2'd2},
    {8'hC3, 2'd1, 1'b0, 1'b1, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // drives one frame from a falling edge; counts falling edges from the start bit
  task automatic send_frame(input logic [7:0] d, input logic [1:0] pm, input logic flip,
                            input logic stopv, input int bitlen, input int ready_at,
                            output int done_at, output int done_cnt);
    logic [10:0] seq;
    int nb;
    int cyc;
    bit pon;
    pon = (pm == 2'd1) || (pm == 2'd2);
    seq = '1;
    seq[0] = 1'b0;
    seq[8:1] = d;
    if (pon) begin
      seq[9]  = ((pm == 2'd2) ? ~(^d) : (^d)) ^ flip;
      seq[10] = stopv;
      nb = 11;
    end else begin
      seq[9] = stopv;
      nb = 10;
    end
    done_at = -1;
    done_cnt = 0;
    cyc = 0;
    @(negedge clk);
    for (int b = 0; b < nb + 1; b++) begin
      rx_line = (b < nb) ? seq[b] : 1'b1;
      for (int k = 0; k < ((b < nb) ? bitlen : 8); k++) begin
        @(negedge clk);
        cyc++;
        if (done_irq) begin
          done_cnt++;
          if (done_at < 0) done_at = cyc;
        end
        rd_ready = (ready_at > 0 && cyc == ready_at);
      end
    end
    rd_ready = 1'b0;
  endtask

  task automatic read_byte();
    @(negedge clk);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int dat, dcnt;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rd_valid after reset", rd_valid, 0);
    chk("R10 rd_data after reset", rd_data, 0);
    chk("R10 flags after reset", {err_parity, err_frame, err_overrun, done_irq}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: only one of the two enables set
    pwr_en = 1'b1; rx_en = 1'b0;
    send_frame(8'h55, 2'd0, 1'b0, 1'b1, 16, 0, dat, dcnt);
    chk("R1 power only: no completion", dcnt, 0);
    chk("R1 power only: nothing pending", rd_valid, 0);
    pwr_en = 1'b0; rx_en = 1'b1;
    send_frame(8'h55, 2'd0, 1'b0, 1'b1, 16, 0, dat, dcnt);
    chk("R1 receive only: no completion", dcnt, 0);
    chk("R1 receive only: nothing pending", rd_valid, 0);
    pwr_en = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d;
      logic [1:0] pm;
      logic fl, st;
      int dv, exp_lat;
      bit pon;
      {d, pm, fl, st} = VEC[v][13:2];
      dv = int'(VEC[v][1:0]);
      pon = (pm == 2'd1) || (pm == 2'd2);
      baud_div = 16'(dv);
      par_mode = pm;
      send_frame(d, pm, fl, st, 16 * ((dv == 0) ? 1 : dv), 0, dat, dcnt);
      exp_lat = pon ? 172 : 156;
      if (dv <= 1) chk($sformatf("R4 R9 latency v%0d", v), dat, exp_lat);
      chk($sformatf("R4 single pulse v%0d", v), dcnt, 1);
      chk($sformatf("R4 R9 data v%0d", v), rd_data, d);
      chk($sformatf("R8 pending v%0d", v), rd_valid, 1);
      chk($sformatf("R5 parity flag v%0d", v), err_parity, pon && fl);
      chk($sformatf("R6 frame flag v%0d", v), err_frame, !st);
      chk($sformatf("R7 no overrun v%0d", v), err_overrun, 0);
      read_byte();
      chk($sformatf("R8 read clears v%0d", v), rd_valid, 0);
      chk($sformatf("R10 flags held after read v%0d", v), err_parity, pon && fl);
    end
    baud_div = 16'd1;
    par_mode = 2'd0;

    // R2: line low from enable onward, then a proper frame
    rx_en = 1'b0;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_en = 1'b1;
    dcnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done_irq) dcnt++;
    end
    chk("R2 low line gives no frame", dcnt, 0);
    chk("R2 nothing pending", rd_valid, 0);
    rx_line = 1'b1;
    repeat (20) @(negedge clk);
    send_frame(8'h96, 2'd0, 1'b0, 1'b1, 16, 0, dat, dcnt);
    chk("R2 frame after high", rd_data, 8'h96);
    read_byte();

    // R3: short low glitch rejected, later frame fine
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    dcnt = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done_irq) dcnt++;
    end
    chk("R3 glitch gives no frame", dcnt, 0);
    chk("R3 glitch nothing pending", rd_valid, 0);
    send_frame(8'h0F, 2'd0, 1'b0, 1'b1, 16, 0, dat, dcnt);
    chk("R3 frame after glitch", rd_data, 8'h0F);

    // R7: second frame with first byte unread
    send_frame(8'hE7, 2'd0, 1'b0, 1'b1, 16, 0, dat, dcnt);
    chk("R7 completion still pulses", dcnt, 1);
    chk("R7 old byte kept", rd_data, 8'h0F);
    chk("R7 still pending", rd_valid, 1);
    chk("R7 overrun flag", err_overrun, 1);

    // R8: read in the completion cycle loads the new byte
    send_frame(8'h42, 2'd0, 1'b0, 1'b1, 16, 155, dat, dcnt);
    chk("R8 same-cycle read new byte", rd_data, 8'h42);
    chk("R8 same-cycle read pending", rd_valid, 1);
    chk("R8 same-cycle read no overrun", err_overrun, 0);
    read_byte();
    chk("R8 final read clears", rd_valid, 0);

    finish_run();
  end
endmodule